// File: doc/BRIEF.md
# Two-Rank DRAM Refresh Scheduler with Shadowed Settings

This block decides when a DRAM controller's command path must send refresh commands to each of two ranks. Software holds a 32-bit control word and a base refresh interval on the block's inputs. Those values form a staging copy. The scheduler runs from an active copy, which is reloaded once when reset is released and afterwards only when the update-toggle bit in the control word changes level. The refresh-rate mode in that word can shorten the interval by two or by four. A change of mode is only accepted while the controller reports that it is in reset or in self-refresh.

A free-running interval timer adds one owed refresh to each rank's counter at every expiry. Owed refreshes are postponed until a rank owes four. They are then offered to the command path through a request that carries a rank number and stays up until it is granted. When both ranks are eligible, the ranks are served in turn.

Setting the disable bit stops the timer at once and drains everything owed, back to back. While the disable bit is set, refreshes come only from per-rank software pulses. Each pulse is issued as soon as the command path accepts it.

Top module: `refresh_sched`

## Requirements
- R1: The control word holds the disable flag at bit 0, the update toggle at bit 1 and the three-bit refresh-rate mode at bits 6:4. While reset is active and right after it, no request is raised, both overflow flags are 0 and the reported active mode is 000.
- R2: On the first clock edge after reset is released, the staged interval and the staged mode are copied into the active copy unconditionally, without a toggle.
- R3: After that first edge, the staged settings are copied into the active copy on the edge after the update toggle changes level, for both 0→1 and 1→0. While the toggle is steady, the active interval stays unchanged.
- R4: A staged mode is taken over only when the controller-in-reset input or the self-refresh input is high in the cycle of the copy. Otherwise the active mode keeps its value, although the interval is still copied.
- R5: Mode 001 halves the active interval and mode 010 quarters it. Every other code, including 101 and 110, runs at the plain interval. The effective interval is never less than one cycle. With the timer enabled from the first edge, the first request appears on edge 1 + 4·E, where E is the effective interval.
- R6: With the disable bit at 0, every expiry of the effective interval adds one owed refresh to both ranks. A rank becomes eligible for a request once it owes at least 4.
- R7: A raised request keeps its rank number and stays high until a grant is seen at a clock edge. That grant removes one owed refresh from that rank.
- R8: When both ranks are eligible, the rank other than the one granted last is chosen. Rank 0 goes first after reset.
- R9: Each rank owes at most 8 refreshes. A software pulse that arrives while its rank is at 8 is dropped and sets that rank's overflow flag, which stays set until reset. Timer expiries at 8 are dropped silently.
- R10: The disable bit acts on the next edge without a toggle. It stops the timer, and every owed refresh of both ranks is then requested back to back until both counts are zero.
- R11: While the disable bit is set, a high sw_refresh bit in a cycle adds one owed refresh to that rank, and any owed count is issued. While the bit is clear, sw_refresh has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 32 | Staged control word (mode, update toggle, disable) |
| base_interval | input | IVW | Staged base refresh interval in cycles |
| ctrl_in_reset | input | 1 | Controller reports it is in reset |
| in_self_refresh | input | 1 | Controller reports it is in self-refresh |
| sw_refresh | input | 2 | Per-rank software refresh pulses |
| refresh_grant | input | 1 | Command path accepts the current request |
| refresh_req | output | 1 | Refresh request |
| refresh_rank | output | 1 | Rank of the current request |
| refresh_overflow | output | 2 | Sticky per-rank dropped-request flags |
| active_mode | output | 3 | Mode code in the active copy |

## Verification
The bench measures the edge on which the first request appears after reset under the plain, halved, quartered, reserved-code and clamped intervals. A design that scaled the interval wrongly or skipped the load at reset release would be early or late by whole intervals. It lets both counts saturate with no grant, then sets the disable bit and counts a strictly alternating drain of exactly sixteen grants. A design that kept the timer running, flushed only one rank or repeated a rank would show a different count or a repeat. It also checks that a mode toggled during normal operation stays out of the active copy, that software pulses are ignored while auto-refresh runs, and that a ninth pulse into a full counter sets only that rank's overflow flag.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  localparam int CW_DIS_BIT  = 0;
  localparam int CW_TOG_BIT  = 1;
  localparam int CW_MODE_LSB = 4;
  localparam int NUM_RANKS   = 2;

  // Right-shift applied to the base interval for a mode code.
  function automatic logic [1:0] rate_shift(input logic [2:0] mode);
    case (mode)
      3'b001:  rate_shift = 2'd1;
      3'b010:  rate_shift = 2'd2;
      default: rate_shift = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/refresh_shadow.sv
module refresh_shadow #(
  parameter int IVW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     stg_mode,
  input  logic [IVW-1:0] stg_ivl,
  input  logic           stg_tog,
  input  logic           mode_ok,
  output logic [2:0]     act_mode,
  output logic [IVW-1:0] act_ivl,
  output logic           init_busy
);
  logic           init_q, init_d;
  logic           tog_q, tog_d;
  logic [2:0]     mode_q, mode_d;
  logic [IVW-1:0] ivl_q, ivl_d;
  logic           load, mode_load;

  always_comb begin
    load      = init_q || (stg_tog != tog_q);
    mode_load = init_q || (load && mode_ok);
    init_d    = 1'b0;
    tog_d     = stg_tog;
    ivl_d     = load ? stg_ivl : ivl_q;
    mode_d    = mode_load ? stg_mode : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b1;
      tog_q  <= 1'b0;
      mode_q <= '0;
      ivl_q  <= '0;
    end else begin
      init_q <= init_d;
      tog_q  <= tog_d;
      mode_q <= mode_d;
      ivl_q  <= ivl_d;
    end
  end

  assign act_mode  = mode_q;
  assign act_ivl   = ivl_q;
  assign init_busy = init_q;

  AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_q && !mode_ok) |=> $stable(mode_q)); // R4
  AST_IVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_q && (stg_tog == tog_q)) |=> $stable(ivl_q)); // R3
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
  import refresh_pkg::*;
#(
  parameter int IVW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [2:0]     mode,
  input  logic [IVW-1:0] ivl,
  output logic           tick
);
  logic [IVW-1:0] cnt_q, cnt_d;
  logic [IVW-1:0] eff, lim;

  always_comb begin
    eff   = ivl >> rate_shift(mode);
    lim   = (eff == '0) ? IVW'(1) : eff;
    tick  = run && (cnt_q >= lim - IVW'(1));
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + IVW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run); // R10
endmodule

// File: rtl/refresh_pend_ctr.sv
module refresh_pend_ctr #(
  parameter int MAX = 8,
  parameter int CW  = $clog2(MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          sw,
  input  logic          sw_en,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          ovf
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          sw_hit, inc, full;

  always_comb begin
    sw_hit = sw && sw_en;
    inc    = tick || sw_hit;
    full   = (cnt_q == CW'(MAX));
    cnt_d  = cnt_q;
    if (inc && !dec && !full) cnt_d = cnt_q + CW'(1);
    else if (dec && !inc)     cnt_d = cnt_q - CW'(1);
    ovf_d = ovf_q || (sw_hit && full && !dec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt     = cnt_q;
  assign cnt_nxt = cnt_d;
  assign ovf     = ovf_q;

  AST_PEND_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R9
  AST_DEC_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt_q != '0)); // R7
endmodule

// File: rtl/refresh_arb.sv
module refresh_arb
  import refresh_pkg::*;
#(
  parameter int CW       = 4,
  parameter int POSTPONE = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_RANKS-1:0][CW-1:0]  cnt,
  input  logic [NUM_RANKS-1:0][CW-1:0]  cnt_nxt,
  input  logic                          drain_all,
  input  logic                          grant,
  output logic                          req,
  output logic                          rank,
  output logic [NUM_RANKS-1:0]          dec
);
  logic                 req_q, req_d;
  logic                 rank_q, rank_d;
  logic                 last_q, last_d;
  logic                 hold;
  logic [NUM_RANKS-1:0] elig;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    assign elig[r] = drain_all ? (cnt_nxt[r] != '0) : (cnt_nxt[r] >= CW'(POSTPONE));
    assign dec[r]  = req_q && grant && (rank_q == r[0]);
  end

  always_comb begin
    hold   = req_q && !grant;
    last_d = (req_q && grant) ? rank_q : last_q;
    req_d  = hold || (|elig);
    rank_d = rank_q;
    if (!hold) begin
      if (&elig)        rank_d = ~last_d;
      else if (elig[1]) rank_d = 1'b1;
      else              rank_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      rank_q <= 1'b0;
      last_q <= 1'b1;
    end else begin
      req_q  <= req_d;
      rank_q <= rank_d;
      last_q <= last_d;
    end
  end

  assign req  = req_q;
  assign rank = rank_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !grant) |=> (req_q && $stable(rank_q))); // R7
  AST_REQ_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (cnt[rank_q] != '0)); // R7
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int IVW      = 16,
  parameter int PEND_MAX = 8,
  parameter int POSTPONE = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [31:0]    ctrl_word,
  input  logic [IVW-1:0] base_interval,
  input  logic           ctrl_in_reset,
  input  logic           in_self_refresh,
  input  logic [1:0]     sw_refresh,
  input  logic           refresh_grant,
  output logic           refresh_req,
  output logic           refresh_rank,
  output logic [1:0]     refresh_overflow,
  output logic [2:0]     active_mode
);
  localparam int CW = $clog2(PEND_MAX + 1);

  logic                         dis;
  logic [2:0]                   act_mode;
  logic [IVW-1:0]               act_ivl;
  logic                         init_busy;
  logic                         tick;
  logic [NUM_RANKS-1:0][CW-1:0] cnt, cnt_nxt;
  logic [NUM_RANKS-1:0]         dec;
  logic                         unused_ctrl_bits;

  assign dis              = ctrl_word[CW_DIS_BIT];
  assign unused_ctrl_bits = ^{ctrl_word[31:7], ctrl_word[3:2]};

  refresh_shadow #(.IVW(IVW)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .stg_mode  (ctrl_word[CW_MODE_LSB +: 3]),
    .stg_ivl   (base_interval),
    .stg_tog   (ctrl_word[CW_TOG_BIT]),
    .mode_ok   (ctrl_in_reset || in_self_refresh),
    .act_mode  (act_mode),
    .act_ivl   (act_ivl),
    .init_busy (init_busy)
  );

  refresh_timer #(.IVW(IVW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (!dis && !init_busy),
    .mode  (act_mode),
    .ivl   (act_ivl),
    .tick  (tick)
  );

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_pend
    refresh_pend_ctr #(.MAX(PEND_MAX), .CW(CW)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .sw      (sw_refresh[r]),
      .sw_en   (dis),
      .dec     (dec[r]),
      .cnt     (cnt[r]),
      .cnt_nxt (cnt_nxt[r]),
      .ovf     (refresh_overflow[r])
    );
  end

  refresh_arb #(.CW(CW), .POSTPONE(POSTPONE)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt),
    .cnt_nxt   (cnt_nxt),
    .drain_all (dis),
    .grant     (refresh_grant),
    .req       (refresh_req),
    .rank      (refresh_rank),
    .dec       (dec)
  );

  assign active_mode = act_mode;

  AST_GRANT_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && refresh_grant && dis && !(|sw_refresh)) |=>
      (cnt[$past(refresh_rank)] == $past(cnt[refresh_rank]) - CW'(1))); // R10
endmodule

// File: tb/test_refresh_sched.sv
`timescale 1ns/1ps
module test_refresh_sched;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ctrl_word;
  logic [15:0] base_interval;
  logic        ctrl_in_reset, in_self_refresh;
  logic [1:0]  sw_refresh;
  logic        refresh_grant;
  logic        refresh_req, refresh_rank;
  logic [1:0]  refresh_overflow;
  logic [2:0]  active_mode;

  int n_chk = 0, n_bad = 0;
  bit grant_en = 1'b0;
  int gcnt0 = 0, gcnt1 = 0, gtotal = 0, alt_err = 0;
  bit last_g = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  refresh_sched i_refresh_sched (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .base_interval(base_interval),
    .ctrl_in_reset(ctrl_in_reset), .in_self_refresh(in_self_refresh),
    .sw_refresh(sw_refresh), .refresh_grant(refresh_grant),
    .refresh_req(refresh_req), .refresh_rank(refresh_rank),
    .refresh_overflow(refresh_overflow), .active_mode(active_mode)
  );

  // Grant driver and grant log, settled 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (grant_en && refresh_req) begin
      if (refresh_rank) gcnt1++; else gcnt0++;
      if (gtotal > 0 && refresh_rank == last_g) alt_err++;
      last_g = refresh_rank;
      gtotal++;
    end
    refresh_grant = grant_en && refresh_req;
  end

  function automatic logic [31:0] mkw(input int mode, input bit tog, input bit dis);
    mkw = '0;
    mkw[6:4] = mode[2:0];
    mkw[1] = tog;
    mkw[0] = dis;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr_log();
    gcnt0 = 0; gcnt1 = 0; gtotal = 0; alt_err = 0;
  endtask

  task automatic do_reset(input logic [31:0] w, input int ivl, input bit creset);
    @(negedge clk);
    rst_n = 1'b0;
    grant_en = 1'b0;
    ctrl_word = w;
    base_interval = 16'(ivl);
    ctrl_in_reset = creset;
    in_self_refresh = 1'b0;
    sw_refresh = 2'b00;
    repeat (3) @(negedge clk);
    clr_log();
    rst_n = 1'b1;
  endtask

  // Called at the release negedge; returns the edge number of the first request.
  task automatic edges_to_req(output int n);
    n = 0;
    while (!refresh_req && n < 3000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_cyc(input int c);
    repeat (c) @(negedge clk);
  endtask

  initial begin
    int n;
    rst_n = 1'b0;
    refresh_grant = 1'b0;
    ctrl_word = '0; base_interval = '0; ctrl_in_reset = 1'b0;
    in_self_refresh = 1'b0; sw_refresh = '0;

    // S1: plain rate, interval 10
    do_reset(mkw(0, 0, 0), 10, 1'b0);
    check(refresh_req == 1'b0, "R1 req after reset", refresh_req, 0);
    check(refresh_overflow == 2'b00, "R1 overflow after reset", refresh_overflow, 0);
    check(active_mode == 3'd0, "R1 mode after reset", active_mode, 0);
    edges_to_req(n);
    check(n == 41, "R2 R5 R6 first request edge 1x", n, 41);
    check(refresh_rank == 1'b0, "R8 rank 0 first", refresh_rank, 0);
    wait_cyc(5);
    check(refresh_req && refresh_rank == 1'b0, "R7 request held without grant",
          {refresh_req, refresh_rank}, 2);
    wait_cyc(60);
    check(refresh_overflow == 2'b00, "R9 timer saturation silent", refresh_overflow, 0);
    clr_log();
    grant_en = 1'b1;
    ctrl_word = mkw(0, 0, 1);
    wait_cyc(40);
    check(gcnt0 == 8, "R10 flush rank0 count", gcnt0, 8);
    check(gcnt1 == 8, "R10 flush rank1 count", gcnt1, 8);
    check(alt_err == 0, "R8 alternating drain", alt_err, 0);
    check(refresh_req == 1'b0, "R10 drained", refresh_req, 0);

    // S2: software requests while disabled
    grant_en = 1'b0;
    clr_log();
    sw_refresh = 2'b01;
    wait_cyc(9);
    sw_refresh = 2'b00;
    wait_cyc(2);
    check(refresh_overflow == 2'b01, "R9 ninth pulse overflow rank0", refresh_overflow, 1);
    check(refresh_req && refresh_rank == 1'b0, "R11 software request raised",
          {refresh_req, refresh_rank}, 2);
    grant_en = 1'b1;
    wait_cyc(30);
    check(gcnt0 == 8 && gcnt1 == 0, "R11 R9 eight rank0 grants", gcnt0 * 10 + gcnt1, 80);
    sw_refresh = 2'b10;
    wait_cyc(1);
    sw_refresh = 2'b00;
    wait_cyc(10);
    check(gcnt1 == 1, "R11 single rank1 pulse", gcnt1, 1);
    wait_cyc(50);
    check(gtotal == 9, "R10 timer stopped while disabled", gtotal, 9);

    // S3: enable with toggled long interval; pulses must be ignored
    ctrl_word = mkw(0, 1, 0);
    base_interval = 16'd1000;
    sw_refresh = 2'b11;
    wait_cyc(5);
    sw_refresh = 2'b00;
    wait_cyc(60);
    ctrl_word = mkw(0, 1, 1);
    wait_cyc(20);
    check(gtotal == 9, "R11 R3 pulses ignored and interval reloaded", gtotal, 9);
    check(refresh_overflow == 2'b01, "R9 overflow sticky", refresh_overflow, 1);

    // S4: half rate loaded in reset, then mode lock
    do_reset(mkw(1, 0, 0), 16, 1'b1);
    edges_to_req(n);
    check(n == 33, "R5 first request edge 2x", n, 33);
    check(active_mode == 3'd1, "R4 mode taken in reset", active_mode, 1);
    ctrl_in_reset = 1'b0;
    ctrl_word = mkw(2, 1, 0);
    wait_cyc(3);
    check(active_mode == 3'd1, "R4 mode locked in normal operation", active_mode, 1);
    in_self_refresh = 1'b1;
    ctrl_word = mkw(2, 0, 0);
    wait_cyc(3);
    check(active_mode == 3'd2, "R3 R4 falling toggle in self-refresh", active_mode, 2);
    in_self_refresh = 1'b0;

    // S5: quarter rate via reset-release load
    do_reset(mkw(2, 0, 0), 16, 1'b0);
    edges_to_req(n);
    check(n == 17, "R2 R5 first request edge 4x", n, 17);

    // S6: unsupported code falls back to plain rate
    do_reset(mkw(5, 0, 0), 12, 1'b0);
    edges_to_req(n);
    check(n == 49, "R5 code 101 runs at 1x", n, 49);
    check(active_mode == 3'd5, "R2 raw mode loaded", active_mode, 5);

    // S7: clamp to one cycle
    do_reset(mkw(2, 0, 0), 2, 1'b0);
    edges_to_req(n);
    check(n == 5, "R5 interval clamped to 1", n, 5);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule